// File: doc/BRIEF.md
# Condition-Code Add/Subtract Unit

This unit adds or subtracts two operands and returns the sum or difference together with a 2-bit condition code. The code has two meanings. After a logical (unsigned) operation, one bit gives carry-out or no-borrow and the other bit says whether the result is nonzero. After a signed operation, the code names one of four outcomes: zero, negative, positive or overflow. Overflow takes priority over the other three.

Each request carries its own width select. In 64-bit mode the full operands are used. In 32-bit mode only the low halves are used and the code is derived from the 32-bit result. A request is marked by a valid strobe. The result, the code and a valid flag are registered and appear on the next clock.

Top module: `cc_addsub_unit`

## Requirements
- R1: Logical add (op_i = 2'b00) returns (a + b) mod 2^W. cc_o[0] is 1 when that result is nonzero, and cc_o[1] is 1 when a carry leaves the top bit. All four codes 0..3 can occur.
- R2: Logical subtract (op_i = 2'b01) returns (a - b) mod 2^W. cc_o[0] is 1 when the result is nonzero, and cc_o[1] is 1 when no borrow occurs (a >= b unsigned). Equal operands therefore give code 2.
- R3: Signed add (op_i = 2'b10) returns code 3 when both operands have the same sign and the result sign differs from it. Otherwise it returns 1 for a negative result, 2 for a positive result and 0 for zero.
- R4: Signed subtract (op_i = 2'b11) returns code 3 when the operand signs differ and the result sign differs from the sign of a. Otherwise it uses the same 0/1/2 rule as R3.
- R5: The opcode is decoded as 00 logical add, 01 logical subtract, 10 signed add, 11 signed subtract. The same rules hold for every operand pattern.
- R6: With wide_i = 0, only a_i[31:0] and b_i[31:0] take part. res_o[63:32] is zero, and carry, sign and overflow are taken at bit 31. With wide_i = 1, all 64 bits are used.
- R7: When valid_i is sampled high on a rising clock edge, res_o, cc_o and valid_o = 1 are presented after that edge. valid_o is 0 after any edge at which valid_i was low.
- R8: When valid_i is low, res_o and cc_o keep their previous values, whatever the other inputs do.
- R9: While rst_ni is low, valid_o, res_o and cc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation select |
| wide_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| res_o | output | 64 | Registered result |
| cc_o | output | 2 | Registered condition code |
| valid_o | output | 1 | Result valid |

## Verification
Random operands almost never produce the rare code points:
- a signed overflow whose truncated result is exactly zero (most-negative plus most-negative),
- a subtract of equal operands,
- a 32-bit carry or overflow whose operands carry nonzero upper halves that must be ignored.

The stimulus reaches these cases with directed vectors built from the extreme values 0, 1, all-ones and the two sign-boundary values at both widths. A random sweep with a behavioural reference model computed in wider arithmetic then covers the remaining cases. Idle cycles with changing operands are placed between requests, so that hold behaviour is compared on every clock.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  typedef enum logic [1:0] {
    OP_LADD = 2'b00,
    OP_LSUB = 2'b01,
    OP_SADD = 2'b10,
    OP_SSUB = 2'b11
  } op_e;
  localparam int unsigned CC_W = 2;
endpackage

// File: rtl/cc_addsub_lane.sv
module cc_addsub_lane #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  // subtract as a + ~b + 1; carry out then means no borrow
  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o   = full[W-1:0];
    carry_o = full[W];
    ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/cc_code_gen.sv
module cc_code_gen
  import cc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  op_e             op_i,
  input  logic [W-1:0]    sum_i,
  input  logic            carry_i,
  input  logic            ovf_i,
  output logic [CC_W-1:0] cc_o
);
  logic nonzero;

  always_comb begin
    nonzero = |sum_i;
    unique case (op_i)
      OP_LADD, OP_LSUB: cc_o = {carry_i, nonzero};
      default: begin
        if (ovf_i)           cc_o = 2'd3;
        else if (!nonzero)   cc_o = 2'd0;
        else if (sum_i[W-1]) cc_o = 2'd1;
        else                 cc_o = 2'd2;
      end
    endcase
  end
endmodule

// File: rtl/cc_addsub_unit.sv
module cc_addsub_unit
  import cc_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [1:0]        cc_o,
  output logic              valid_o
);
  localparam int unsigned NUM_LANES = 2;

  op_e              op;
  logic [DATA_W-1:0] lane_res [NUM_LANES];
  logic [CC_W-1:0]   lane_cc  [NUM_LANES];
  logic [DATA_W-1:0] res_d;
  logic [CC_W-1:0]   cc_d;
  logic [DATA_W-1:0] res_q;
  logic [CC_W-1:0]   cc_q;
  logic              valid_q;

  assign op = op_e'(op_i);

  // lane 0 = narrow, lane 1 = full width
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = (g == 0) ? NARROW_W : DATA_W;
    logic [LW-1:0] sum;
    logic          carry;
    logic          ovf;

    cc_addsub_lane #(.W(LW)) u_lane (
      .a_i    (a_i[LW-1:0]),
      .b_i    (b_i[LW-1:0]),
      .sub_i  (op_i[0]),
      .sum_o  (sum),
      .carry_o(carry),
      .ovf_o  (ovf)
    );

    cc_code_gen #(.W(LW)) u_cc (
      .op_i   (op),
      .sum_i  (sum),
      .carry_i(carry),
      .ovf_i  (ovf),
      .cc_o   (lane_cc[g])
    );

    if (LW < DATA_W) begin : g_ext
      assign lane_res[g] = {{(DATA_W-LW){1'b0}}, sum};
    end else begin : g_full
      assign lane_res[g] = sum;
    end
  end

  assign res_d = wide_i ? lane_res[1] : lane_res[0];
  assign cc_d  = wide_i ? lane_cc[1]  : lane_cc[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      cc_q    <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        cc_q  <= cc_d;
      end
    end
  end

  assign res_o   = res_q;
  assign cc_o    = cc_q;
  assign valid_o = valid_q;

  assert_valid_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(cc_o)));
  assert_narrow_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (res_o[DATA_W-1:NARROW_W] == '0));
  assert_equal_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_i && op_i == 2'b01 && a_i == b_i) |=> (cc_o == 2'd2));
  assert_add_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_i && op_i == 2'b00 && b_i == '0) |=> (cc_o[1] == 1'b0));
endmodule

// File: tb/cc_addsub_unit_bench.sv
module cc_addsub_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        wide = 1'b1;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [63:0] res;
  logic [1:0]  cc;
  logic        vo;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_res = '0;
  logic [1:0]  exp_cc = '0;
  logic        exp_v = 1'b0;

  localparam logic [63:0] MAX64 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMAX  = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN  = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  cc_addsub_unit u_cc_addsub_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .wide_i(wide),
    .a_i(a), .b_i(b), .res_o(res), .cc_o(cc), .valid_o(vo)
  );

  // behavioural reference: wide arithmetic, then classify
  function automatic logic [65:0] ref_model(logic [1:0] o, logic w,
                                            logic [63:0] x, logic [63:0] y);
    int          n;
    logic [63:0] m;
    logic [63:0] xa, ya, r;
    logic [65:0] ex;
    logic [65:0] lo_lim, hi_lim;
    logic [1:0]  c;
    logic        neg;
    n  = w ? 64 : 32;
    m  = w ? MAX64 : 64'h0000_0000_FFFF_FFFF;
    xa = x & m;
    ya = y & m;
    if (o[0]) r = (xa - ya) & m;
    else      r = (xa + ya) & m;
    neg = r[n-1];
    if (!o[1]) begin
      if (o[0]) c = {(xa >= ya), (r != 0)};
      else      c = {({2'b0, xa} + {2'b0, ya}) > {2'b0, m}, (r != 0)};
    end else begin
      logic signed [65:0] sx, sy, sr;
      sx = w ? $signed({{2{x[63]}}, x}) : $signed({{34{x[31]}}, x[31:0]});
      sy = w ? $signed({{2{y[63]}}, y}) : $signed({{34{y[31]}}, y[31:0]});
      sr = o[0] ? sx - sy : sx + sy;
      ex = sr;
      hi_lim = w ? {2'b00, SMAX} : 66'h0_7FFF_FFFF;
      lo_lim = w ? {2'b11, SMIN} : {34'h3_FFFF_FFFF, 32'h8000_0000};
      if ($signed(ex) > $signed(hi_lim) || $signed(ex) < $signed(lo_lim)) c = 2'd3;
      else if (r == 0) c = 2'd0;
      else if (neg)    c = 2'd1;
      else             c = 2'd2;
    end
    return {c, r};
  endfunction

  task automatic check(string tag);
    total++;
    if (vo !== exp_v || res !== exp_res || cc !== exp_cc) begin
      bad++;
      $display("FAIL %s: got v=%0b res=%h cc=%0d, expected v=%0b res=%h cc=%0d",
               tag, vo, res, cc, exp_v, exp_res, exp_cc);
    end
  endtask

  task automatic step(logic v, logic [1:0] o, logic w, logic [63:0] x,
                      logic [63:0] y, string tag);
    logic [65:0] e;
    valid = v; op = o; wide = w; a = x; b = y;
    @(posedge clk);
    e = ref_model(o, w, x, y);
    exp_v = v;
    if (v) begin
      exp_cc  = e[65:64];
      exp_res = e[63:0];
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release");

    // R1 logical add
    step(1, 2'b00, 1, 64'd0, 64'd0, "R1 zero");
    step(1, 2'b00, 1, 64'd1, 64'd1, "R1 nonzero");
    step(1, 2'b00, 1, MAX64, 64'd1, "R1 carry zero");
    step(1, 2'b00, 1, MAX64, MAX64, "R1 carry nonzero");
    // R2 logical subtract
    step(1, 2'b01, 1, 64'd5, 64'd5, "R2 equal");
    step(1, 2'b01, 1, 64'd3, 64'd5, "R2 borrow");
    step(1, 2'b01, 1, 64'd5, 64'd3, "R2 no borrow");
    step(1, 2'b01, 1, 64'd0, 64'd0, "R2 zeros");
    // R3 signed add
    step(1, 2'b10, 1, SMAX, 64'd1, "R3 pos overflow");
    step(1, 2'b10, 1, SMIN, SMIN, "R3 overflow zero result");
    step(1, 2'b10, 1, MAX64, MAX64, "R3 negative");
    step(1, 2'b10, 1, 64'd1, MAX64, "R3 zero");
    step(1, 2'b10, 1, 64'd2, 64'd3, "R3 positive");
    // R4 signed subtract
    step(1, 2'b11, 1, SMIN, 64'd1, "R4 neg overflow");
    step(1, 2'b11, 1, 64'd0, SMIN, "R4 pos overflow");
    step(1, 2'b11, 1, 64'd5, 64'd5, "R4 zero");
    step(1, 2'b11, 1, 64'd3, 64'd5, "R4 negative");
    step(1, 2'b11, 1, MAX64, SMAX, "R4 no overflow");
    // R6 narrow mode with garbage in upper halves
    step(1, 2'b00, 0, 64'hDEAD_BEEF_FFFF_FFFF, 64'hCAFE_0000_0000_0001, "R6 narrow carry");
    step(1, 2'b01, 0, 64'h1234_0000_0000_0007, 64'h0000_0001_0000_0007, "R6 narrow equal");
    step(1, 2'b10, 0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, "R6 narrow overflow");
    step(1, 2'b11, 0, 64'h0000_0000_8000_0000, 64'hFFFF_0000_0000_0001, "R6 narrow sub overflow");
    step(1, 2'b10, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R6 narrow negative");
    // R8 hold with changing inputs
    step(0, 2'b00, 1, MAX64, MAX64, "R8 hold");
    step(0, 2'b11, 0, 64'd7, 64'd9, "R8 hold");
    step(1, 2'b00, 1, 64'd10, 64'd20, "R7 back to back");
    step(1, 2'b11, 1, 64'd10, 64'd20, "R7 back to back");
    // R5 random sweep across opcodes and widths
    for (int i = 0; i < 400; i++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (i % 7 == 0) y = x;
      if (i % 11 == 0) x = (i % 2) ? SMIN : SMAX;
      step((i % 5) != 0, 2'(i % 4), (i % 3) != 0, x, y, "R5 sweep");
    end
    // R9 reset mid-stream
    valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    exp_v = 1'b0; exp_res = '0; exp_cc = '0;
    #1;
    check("R9 async reset");
    @(negedge clk);
    check("R9 held in reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule